// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Responder

This block answers a host that bit-bangs a two-wire serial memory bus. Each time the host updates its clock and data levels it pulses an update strobe. The block compares the new levels with the ones it stored on the previous update. From that comparison it detects start and stop conditions and clock rising edges, and it counts the clock bits it accepts. It returns one data bit that the host reads back.

After a start condition the block collects a command byte, MSB first. It then drives an acknowledge on the ninth clock. The low bit of the command chooses what happens on clocks 10 to 17: either a word address is shifted in, or the held data byte is shifted out MSB first. After the 17th clock the data byte is reloaded from the addressed location, and the 18th clock is acknowledged as well.

The memory content is fixed and computed from a parameter. A depth parameter selects either 256 or 128 bytes. The block never stores write data.

Top module: `seep_resp`

## Requirements
- R1: The memory holds DEPTH bytes, 256 or 128, and byte i holds (i*29 + SEED) mod 256, with SEED defaulting to 8'h5A. With DEPTH=128 only the low 7 address bits select a byte.
- R2: A start (data falls while the clock is high on both the previous and the current update) clears the clock count and the command and activates the block. A stop (data rises under the same clock condition) clears the count, deactivates the block and sets the output to 1.
- R3: While the block is inactive, every update other than a start is ignored. The count, command and output do not change.
- R4: A clock bit is accepted only on a clock rising edge where the data level equals its previous level. Each accepted bit advances the count by one. A rising edge with changed data is not counted.
- R5: Accepted clocks 1 to 8 shift the data level into the command, MSB first.
- R6: On accepted clocks 9 and 18 the output is driven to 0 (acknowledge).
- R7: When command bit 0 is 0, clocks 10 to 17 shift the data level into the word address, MSB first. On clock 17 the data byte is loaded from the new address.
- R8: When command bit 0 is 1, clocks 10 to 17 put the data register's MSB on the output and shift the register left. On clock 17 the register is reloaded from the unchanged address. The data register and the address reset to 0.
- R9: The output resets to 1 and reads 1 on every accepted clock that is neither an acknowledge nor a read-data clock.
- R10: Accepted clocks after the 18th leave the count unchanged and return 1, until the next start.
- R11: While upd_i is low, the clock and data inputs are not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Host update strobe, one cycle per level change |
| scl_i | input | 1 | Bus clock level written by the host |
| sda_i | input | 1 | Bus data level written by the host |
| sda_o | output | 1 | Data bit the host reads back |

## Verification
The assertions assume that the host levels change only together with an update strobe. They also assume that a start and a stop cannot occur on the same update. They treat every strobe as a single host write, so a strobe that repeats the previous levels must be harmless. The bench keeps to these assumptions: every level change goes through one task that raises upd_i for exactly one cycle. Only the test for R11 changes the levels with the strobe low, and it returns them to their stored values before the next strobe.

// File: rtl/seep_pkg.sv
package seep_pkg;
  localparam int unsigned TICK_W   = 5;
  localparam int unsigned CLK_ACK0 = 9;
  localparam int unsigned CLK_PAY0 = 10;
  localparam int unsigned CLK_LAST = 17;
  localparam int unsigned CLK_ACK1 = 18;

  function automatic logic [7:0] seep_fill(int unsigned idx, logic [7:0] seed);
    logic [7:0] prod;
    prod = 8'((idx * 29) & 255);
    return prod + seed;
  endfunction
endpackage

// File: rtl/seep_bus_mon.sv
module seep_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic take_o,
  output logic bit_o
);
  logic scl_q, sda_q, cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (upd_i) begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign cond    = upd_i & scl_q & scl_i & (sda_q != sda_i);
  assign start_o = cond & ~sda_i;
  assign stop_o  = cond & sda_i;
  assign take_o  = upd_i & ~scl_q & scl_i & (sda_q == sda_i);
  assign bit_o   = sda_i;
endmodule

// File: rtl/seep_rom.sv
module seep_rom #(
  parameter int unsigned DEPTH = 256,
  parameter logic [7:0]  SEED  = 8'h5A
) (
  input  logic [7:0] addr_i,
  output logic [7:0] data_o
);
  import seep_pkg::*;
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_fill
    assign mem[g] = seep_fill(g, SEED);
  end

  assign data_o = mem[int'(addr_i) % int'(DEPTH)];
endmodule

// File: rtl/seep_resp.sv
module seep_resp #(
  parameter int unsigned DEPTH = 256,
  parameter logic [7:0]  SEED  = 8'h5A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  import seep_pkg::*;

  localparam logic [TICK_W-1:0] T_ACK0 = TICK_W'(CLK_ACK0);
  localparam logic [TICK_W-1:0] T_PAY0 = TICK_W'(CLK_PAY0);
  localparam logic [TICK_W-1:0] T_LAST = TICK_W'(CLK_LAST);
  localparam logic [TICK_W-1:0] T_ACK1 = TICK_W'(CLK_ACK1);

  logic start_w, stop_w, take_w, bit_w;
  logic active_q;
  logic [TICK_W-1:0] tick_q, tick_nxt;
  logic [7:0] cmd_q, addr_q, data_q, addr_nxt, rom_addr, rom_data;
  logic out_q;

  seep_bus_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start_w),
    .stop_o (stop_w),
    .take_o (take_w),
    .bit_o  (bit_w)
  );

  assign tick_nxt = tick_q + 1'b1;
  assign addr_nxt = {addr_q[6:0], bit_w};
  assign rom_addr = cmd_q[0] ? addr_q : addr_nxt;

  seep_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .addr_i(rom_addr),
    .data_o(rom_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      out_q    <= 1'b1;
    end else if (start_w) begin
      active_q <= 1'b1;
      tick_q   <= '0;
      cmd_q    <= '0;
      out_q    <= 1'b1;
    end else if (stop_w) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      out_q    <= 1'b1;
    end else if (take_w && active_q) begin
      if (tick_q < T_ACK1) tick_q <= tick_nxt;
      if (tick_nxt < T_ACK0) begin
        cmd_q <= {cmd_q[6:0], bit_w};
        out_q <= 1'b1;
      end else if (tick_nxt == T_ACK0) begin
        out_q <= 1'b0;
      end else if (tick_nxt >= T_PAY0 && tick_nxt <= T_LAST) begin
        if (cmd_q[0]) begin
          out_q  <= data_q[7];
          data_q <= {data_q[6:0], 1'b0};
        end else begin
          addr_q <= addr_nxt;
          out_q  <= 1'b1;
        end
        // last payload clock: fetch overrides the shift
        if (tick_nxt == T_LAST) data_q <= rom_data;
      end else if (tick_nxt == T_ACK1) begin
        out_q <= 1'b0;
      end else begin
        out_q <= 1'b1;
      end
    end
  end

  assign sda_o = out_q;
endmodule

// File: rtl/seep_resp_chk.sv
module seep_resp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       take_i,
  input logic       active_i,
  input logic [4:0] tick_i,
  input logic [7:0] cmd_i,
  input logic       sda_o
);
  p_start_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_i && tick_i == 5'd0 && cmd_i == 8'd0);

  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !active_i && sda_o && tick_i == 5'd0);

  p_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !start_i) |=> $stable(tick_i) && $stable(cmd_i) && sda_o);

  p_tick_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && active_i && tick_i < 5'd18) |=> tick_i == $past(tick_i) + 5'd1);

  p_no_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !take_i && !start_i && !stop_i) |=> $stable(tick_i) && $stable(sda_o));

  p_cmd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tick_i >= 5'd8 && !start_i) |=> $stable(cmd_i));

  p_ack_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && active_i && (tick_i == 5'd8 || tick_i == 5'd17)) |=> !sda_o);

  p_late_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && active_i && tick_i == 5'd18) |=> sda_o && tick_i == 5'd18);
endmodule

bind seep_resp seep_resp_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_w),
  .stop_i  (stop_w),
  .take_i  (take_w),
  .active_i(active_q),
  .tick_i  (tick_q),
  .cmd_i   (cmd_q),
  .sda_o   (sda_o)
);

// File: tb/seep_resp_tb.sv
`timescale 1ns/1ps
module seep_resp_tb;
  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, scl = 1'b1, sda = 1'b1;
  logic out_a, out_b;
  int checks = 0, errors = 0;
  logic [7:0] last_addr;

  always #2 clk = ~clk;

  seep_resp u_dut (.clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .scl_i(scl), .sda_i(sda), .sda_o(out_a));
  seep_resp #(.DEPTH(128)) u_dut128 (.clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .scl_i(scl), .sda_i(sda), .sda_o(out_b));

  // {write command, read command, word address}
  localparam logic [23:0] VEC [6] = '{
    {8'hA0, 8'hA1, 8'h00}, {8'h00, 8'h01, 8'h01}, {8'hFE, 8'hFF, 8'h7F},
    {8'h40, 8'hC1, 8'h80}, {8'h12, 8'h35, 8'hFF}, {8'hA0, 8'hA1, 8'hC5}};

  function automatic logic [7:0] exp_byte(logic [7:0] a, int depth);
    return 8'(((int'(a) % depth) * 29 + 'h5A) & 255);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic d);
    @(negedge clk); scl = s; sda = d; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic clk_bit(logic b, output logic oa, output logic ob);
    drive(1'b0, b); drive(1'b1, b); oa = out_a; ob = out_b; drive(1'b0, b);
  endtask

  task automatic do_start();
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
  endtask

  task automatic send_byte(logic [7:0] v, output logic [7:0] ra, output logic [7:0] rb);
    logic oa, ob;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(v[i], oa, ob); ra[i] = oa; rb[i] = ob;
    end
  endtask

  task automatic txn_write(logic [7:0] cmd, logic [7:0] addr);
    logic [7:0] ra, rb; logic oa, ob;
    do_start();
    send_byte(cmd, ra, rb);
    check("R9 idle during command", ra, 8'hFF);
    clk_bit(1'b1, oa, ob);
    check("R6 ack clock 9 write", {7'd0, oa}, 8'd0);
    send_byte(addr, ra, rb);
    check("R9 idle during address", ra, 8'hFF);
    clk_bit(1'b1, oa, ob);
    check("R6 ack clock 18 write", {7'd0, oa}, 8'd0);
    do_stop();
  endtask

  task automatic txn_read(logic [7:0] cmd, logic [7:0] ea, logic [7:0] eb);
    logic [7:0] ra, rb; logic oa, ob;
    do_start();
    send_byte(cmd, ra, rb);
    clk_bit(1'b1, oa, ob);
    check("R6 ack clock 9 read", {7'd0, oa}, 8'd0);
    send_byte(8'hFF, ra, rb);
    check("R7 R8 read byte", ra, ea);
    check("R1 read byte depth 128", rb, eb);
    clk_bit(1'b1, oa, ob);
    check("R6 ack clock 18 read", {7'd0, oa}, 8'd0);
    do_stop();
    check("R2 output high after stop", {7'd0, out_a}, 8'd1);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb; logic oa, ob;
    repeat (3) @(negedge clk);
    check("R9 reset output", {7'd0, out_a}, 8'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 output after reset", {6'd0, out_a, out_b}, 8'd3);

    // R8: read before any address: data register reset value
    do_start();
    send_byte(8'hA1, ra, rb);
    clk_bit(1'b1, oa, ob);
    check("R6 first ack", {7'd0, oa}, 8'd0);
    send_byte(8'hFF, ra, rb);
    check("R8 reset data byte", ra, 8'h00);
    clk_bit(1'b1, oa, ob);
    check("R6 first ack 18", {7'd0, oa}, 8'd0);
    clk_bit(1'b0, oa, ob);
    check("R10 clock 19", {7'd0, oa}, 8'd1);
    clk_bit(1'b1, oa, ob);
    check("R10 clock 20", {7'd0, oa}, 8'd1);
    do_stop();

    // table: write address then read it back (R5 MSB-first command, R7, R1)
    for (int v = 0; v < 6; v++) begin
      txn_write(VEC[v][23:16], VEC[v][7:0]);
      txn_read(VEC[v][15:8], exp_byte(VEC[v][7:0], 256), exp_byte(VEC[v][7:0], 128));
      last_addr = VEC[v][7:0];
    end

    // R3: clocks while inactive do nothing
    send_byte(8'h5C, ra, rb);
    check("R3 inactive outputs", ra, 8'hFF);
    clk_bit(1'b0, oa, ob);
    check("R3 no ack when inactive", {7'd0, oa}, 8'd1);
    txn_read(8'hA1, exp_byte(last_addr, 256), exp_byte(last_addr, 128));

    // R4: rising edge with changed data is not counted
    do_start();
    for (int i = 7; i >= 4; i--) clk_bit(1'(8'hA0 >> i), oa, ob);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    for (int i = 3; i >= 0; i--) clk_bit(1'(8'hA0 >> i), oa, ob);
    clk_bit(1'b1, oa, ob);
    check("R4 ack after 8 accepted bits", {7'd0, oa}, 8'd0);
    send_byte(8'h21, ra, rb);
    clk_bit(1'b1, oa, ob);
    do_stop();
    txn_read(8'hA1, exp_byte(8'h21, 256), exp_byte(8'h21, 128));

    // R11: start pattern without strobe is not seen
    @(negedge clk); scl = 1'b1; sda = 1'b0;
    repeat (3) @(negedge clk);
    sda = 1'b1;
    @(negedge clk);
    send_byte(8'hA1, ra, rb);
    clk_bit(1'b1, oa, ob);
    check("R11 unstrobed start ignored", {7'd0, oa}, 8'd1);

    // R2: stop mid-command aborts, next transaction starts fresh
    do_start();
    for (int i = 7; i >= 4; i--) clk_bit(1'(8'hA1 >> i), oa, ob);
    do_stop();
    check("R2 stop mid-command", {7'd0, out_a}, 8'd1);
    txn_read(8'hA1, exp_byte(8'h21, 256), exp_byte(8'h21, 128));

    // R7: second read from same address repeats the byte
    txn_read(8'h01, exp_byte(8'h21, 256), exp_byte(8'h21, 128));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule